// File: doc/BRIEF.md
# Selectable PRBS Self-Test Checker

This block is a built-in self-test engine for a serial data path. A transmit side emits a continuous pseudo-random bit stream. A receive side checks a returning stream against the same sequence. The two sides are independent, so the returning stream may come from an internal loopback or from an external fixture. Software writes a start/stop control, and that write also chooses a short (9-stage) or a long (15-stage) sequence. Software then reads a pass/fail bit and a count of bit errors.

The receive side locks to the incoming stream on its own. It fills its register with the first received bits and only then begins predicting each bit. Once locked, it feeds its own predicted bits back, so a single corrupted bit costs one error and does not throw off the prediction. Pass is reported only after a run of clean comparisons. The first mismatch pins the status at fail. Only the next write of the control clears that, and the same write also clears the error count.

Top module: `prbs_selftest`

## Requirements
- R1: After reset, pass_o is 0, err_cnt_o is 0 and tx_vld_o is 0.
- R2: With seq_sel_i = 0 at the start write, the first transmitted bit appears the cycle after the write. Bit n equals bit n-9 XOR bit n-5, and every bit before n = 0 counts as 1 (register seeded all ones, polynomial x^9+x^5+1).
- R3: With seq_sel_i = 1 at the start write, the same rule holds with lags 15 and 14 (x^15+x^14+1, seeded all ones).
- R4: tx_vld_o is 1 in every cycle after a write with start_val_i = 1 and until a write with start_val_i = 0. After that write it is 0.
- R5: While running, the checker takes the first N valid received bits (N = 9 or 15) into its register without comparing. Cycles with rx_vld_i = 0 are ignored.
- R6: pass_o becomes 1 in the cycle after the 64th consecutive matching comparison, if no error has latched since the last write.
- R7: A mismatch forces pass_o to 0. pass_o stays 0 through any number of later matches until the next start/stop write.
- R8: Each mismatch adds one to err_cnt_o. The count saturates at 255.
- R9: Any start/stop write clears err_cnt_o and pass_o in the following cycle.
- R10: The sequence length is taken only at the start write. A change of seq_sel_i during a run has no effect on either side.
- R11: While stopped, received bits are not compared and do not change err_cnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_wr_i | input | 1 | One-cycle write strobe for the start/stop control |
| start_val_i | input | 1 | Value written: 1 starts, 0 stops |
| seq_sel_i | input | 1 | Sequence length: 0 short (9), 1 long (15) |
| tx_bit_o | output | 1 | Transmitted pseudo-random bit |
| tx_vld_o | output | 1 | Transmit stream active |
| rx_bit_i | input | 1 | Received bit |
| rx_vld_i | input | 1 | Received bit valid |
| pass_o | output | 1 | 1 = pass, 0 = fail |
| err_cnt_o | output | 8 | Saturating mismatch count |

## Verification
The bench checks a full period of the short sequence and a long stretch of the long one against a recurrence model. A wrong tap or seed would show up at the first bit that differs. It feeds the checker streams that begin at arbitrary offsets. A checker that compares during lock-in, or that seeds instead of loading, would count errors on clean data. The bench probes pass exactly at the 63rd and 64th clean comparison, so an off-by-one in the run length is caught. A burst of 300 inverted bits exposes a counter that wraps. Clean bits sent after an error expose a pass bit that recovers on its own. The bench also flips the select during a run and sends bits while stopped; either would corrupt the stream or the count if it were not ignored.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  typedef enum logic {SEQ_SHORT = 1'b0, SEQ_LONG = 1'b1} seq_sel_e;

  typedef struct packed {
    logic vld;
    logic err;
  } cmp_t;
endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_wr_i,
  input  logic     start_val_i,
  input  logic     seq_sel_i,
  output logic     run_o,
  output seq_sel_e sel_o,
  output logic     seed_o,
  output logic     clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      sel_o <= SEQ_SHORT;
    end else if (start_wr_i) begin
      run_o <= start_val_i;
      if (start_val_i) sel_o <= seq_sel_e'(seq_sel_i);
    end
  end

  assign seed_o = start_wr_i & start_val_i;
  assign clr_o  = start_wr_i;
endmodule

// File: rtl/prbs_fb.sv
module prbs_fb
  import prbs_pkg::*;
#(
  parameter int LEN_S = 9,
  parameter int TAP_S = 5,
  parameter int LEN_L = 15,
  parameter int TAP_L = 14,
  localparam int W = (LEN_L > LEN_S) ? LEN_L : LEN_S
) (
  input  logic [W-1:0] st_i,
  input  seq_sel_e     sel_i,
  output logic         fb_o
);
  localparam logic [W-1:0] MASK_S = (W'(1) << (LEN_S - 1)) | (W'(1) << (TAP_S - 1));
  localparam logic [W-1:0] MASK_L = (W'(1) << (LEN_L - 1)) | (W'(1) << (TAP_L - 1));

  assign fb_o = (sel_i == SEQ_LONG) ? ^(st_i & MASK_L) : ^(st_i & MASK_S);
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter int LEN_S = 9,
  parameter int TAP_S = 5,
  parameter int LEN_L = 15,
  parameter int TAP_L = 14,
  localparam int W = (LEN_L > LEN_S) ? LEN_L : LEN_S
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     seed_i,
  input  logic     run_i,
  input  seq_sel_e sel_i,
  output logic     bit_o,
  output logic     vld_o
);
  logic [W-1:0] st_q;
  logic         fb;

  prbs_fb #(.LEN_S(LEN_S), .TAP_S(TAP_S), .LEN_L(LEN_L), .TAP_L(TAP_L)) u_fb (
    .st_i (st_q),
    .sel_i(sel_i),
    .fb_o (fb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '1;
    else if (seed_i) st_q <= '1;
    else if (run_i)  st_q <= {st_q[W-2:0], fb};
  end

  assign bit_o = fb;
  assign vld_o = run_i;
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_pkg::*;
#(
  parameter int LEN_S = 9,
  parameter int TAP_S = 5,
  parameter int LEN_L = 15,
  parameter int TAP_L = 14,
  localparam int W  = (LEN_L > LEN_S) ? LEN_L : LEN_S,
  localparam int CW = $clog2(W + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     run_i,
  input  seq_sel_e sel_i,
  input  logic     rx_bit_i,
  input  logic     rx_vld_i,
  output cmp_t     cmp_o
);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] sync_q;
  logic [CW-1:0] len_cur;
  logic          fb, take, locked;

  prbs_fb #(.LEN_S(LEN_S), .TAP_S(TAP_S), .LEN_L(LEN_L), .TAP_L(TAP_L)) u_fb (
    .st_i (sh_q),
    .sel_i(sel_i),
    .fb_o (fb)
  );

  assign len_cur = (sel_i == SEQ_LONG) ? CW'(LEN_L) : CW'(LEN_S);
  assign locked  = (sync_q == len_cur);
  assign take    = run_i & rx_vld_i;

  // lock-in loads received bits; once locked, predicted bits are fed back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      sync_q <= '0;
    end else if (clr_i) begin
      sh_q   <= '0;
      sync_q <= '0;
    end else if (take) begin
      if (!locked) begin
        sh_q   <= {sh_q[W-2:0], rx_bit_i};
        sync_q <= sync_q + 1'b1;
      end else begin
        sh_q   <= {sh_q[W-2:0], fb};
      end
    end
  end

  assign cmp_o.vld = take & locked;
  assign cmp_o.err = take & locked & (rx_bit_i ^ fb);
endmodule

// File: rtl/prbs_status.sv
module prbs_status
  import prbs_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PASS_RUN = 64,
  localparam int RW = $clog2(PASS_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  cmp_t             cmp_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic          latched_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o    <= 1'b0;
      cnt_o     <= '0;
      latched_q <= 1'b0;
      run_q     <= '0;
    end else if (clr_i) begin
      pass_o    <= 1'b0;
      cnt_o     <= '0;
      latched_q <= 1'b0;
      run_q     <= '0;
    end else if (cmp_i.vld) begin
      if (cmp_i.err) begin
        pass_o    <= 1'b0;
        latched_q <= 1'b1;
        run_q     <= '0;
        if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
      end else begin
        if (run_q != RW'(PASS_RUN)) run_q <= run_q + 1'b1;
        if (run_q == RW'(PASS_RUN - 1) && !latched_q) pass_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prbs_selftest.sv
module prbs_selftest
  import prbs_pkg::*;
#(
  parameter int LEN_S    = 9,
  parameter int TAP_S    = 5,
  parameter int LEN_L    = 15,
  parameter int TAP_L    = 14,
  parameter int CNT_W    = 8,
  parameter int PASS_RUN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_wr_i,
  input  logic             start_val_i,
  input  logic             seq_sel_i,
  output logic             tx_bit_o,
  output logic             tx_vld_o,
  input  logic             rx_bit_i,
  input  logic             rx_vld_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic     run, seed, clr;
  seq_sel_e sel;
  cmp_t     cmp;

  prbs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_wr_i (start_wr_i),
    .start_val_i(start_val_i),
    .seq_sel_i  (seq_sel_i),
    .run_o      (run),
    .sel_o      (sel),
    .seed_o     (seed),
    .clr_o      (clr)
  );

  prbs_gen #(.LEN_S(LEN_S), .TAP_S(TAP_S), .LEN_L(LEN_L), .TAP_L(TAP_L)) u_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .seed_i(seed),
    .run_i (run),
    .sel_i (sel),
    .bit_o (tx_bit_o),
    .vld_o (tx_vld_o)
  );

  prbs_chk #(.LEN_S(LEN_S), .TAP_S(TAP_S), .LEN_L(LEN_L), .TAP_L(TAP_L)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .run_i   (run),
    .sel_i   (sel),
    .rx_bit_i(rx_bit_i),
    .rx_vld_i(rx_vld_i),
    .cmp_o   (cmp)
  );

  prbs_status #(.CNT_W(CNT_W), .PASS_RUN(PASS_RUN)) u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .cmp_i (cmp),
    .pass_o(pass_o),
    .cnt_o (err_cnt_o)
  );
endmodule

// File: rtl/prbs_selftest_sva.sv
module prbs_selftest_sva #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_wr_i,
  input logic             start_val_i,
  input logic             tx_vld_o,
  input logic             rx_vld_i,
  input logic             pass_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  p_clear_on_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i |=> (err_cnt_o == '0) && !pass_o);

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == '1) && !start_wr_i |=> err_cnt_o == '1);

  p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_wr_i |=> (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + 1'b1));

  p_start_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i && start_val_i |=> tx_vld_o);

  p_stop_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i && !start_val_i |=> !tx_vld_o);

  p_idle_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_vld_i && !start_wr_i |=> $stable(err_cnt_o));

  p_stopped_rx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_vld_o && !start_wr_i |=> $stable(err_cnt_o) && $stable(pass_o));

  p_fail_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != '0) && !start_wr_i |=> !pass_o);
endmodule

bind prbs_selftest prbs_selftest_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_wr_i (start_wr_i),
  .start_val_i(start_val_i),
  .tx_vld_o   (tx_vld_o),
  .rx_vld_i   (rx_vld_i),
  .pass_o     (pass_o),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/sim_prbs_selftest.sv
`timescale 1ns/1ps
module sim_prbs_selftest;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_wr_i = 1'b0, start_val_i = 1'b0, seq_sel_i = 1'b0;
  logic       rx_bit_i = 1'b0, rx_vld_i = 1'b0;
  logic       tx_bit_o, tx_vld_o, pass_o;
  logic [7:0] err_cnt_o;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  bit  s9 [2048];
  bit  s15[2048];

  always #2.5 clk_i = ~clk_i;

  prbs_selftest u0 (.*);

  function automatic void build(int len, int tap, ref bit s[2048]);
    for (int n = 0; n < 2048; n++) begin
      bit a = (n >= len) ? s[n-len] : 1'b1;
      bit b = (n >= tap) ? s[n-tap] : 1'b1;
      s[n] = a ^ b;
    end
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit v);
    @(negedge clk_i); start_wr_i = 1'b1; start_val_i = v;
    @(posedge clk_i); #1 start_wr_i = 1'b0;
  endtask

  task automatic send(bit b);
    @(negedge clk_i); rx_vld_i = 1'b1; rx_bit_i = b;
    @(posedge clk_i); #1 rx_vld_i = 1'b0;
  endtask

  task automatic idle_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); rx_vld_i = 1'b0; rx_bit_i = ~rx_bit_i;
    end
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p;
    build(9, 5, s9);
    build(15, 14, s15);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(pass_o == 0, "R1 pass", pass_o, 0);
    chk(err_cnt_o == 0, "R1 cnt", err_cnt_o, 0);
    chk(tx_vld_o == 0, "R1 vld", tx_vld_o, 0);

    // R2: full short period and beyond
    seq_sel_i = 1'b0;
    wr(1'b1);
    for (int i = 0; i < 600; i++) begin
      chk(tx_vld_o == 1, "R4 vld run", tx_vld_o, 1);
      chk(tx_bit_o == s9[i], "R2 tx bit", tx_bit_o, s9[i]);
      @(posedge clk_i); #1;
    end

    // R5/R6: lock from offset, junk on invalid cycles
    wr(1'b1);
    p = 37;
    for (int i = 0; i < 9; i++) begin
      send(s9[p]); p++;
      idle_junk(2);
    end
    chk(err_cnt_o == 0, "R5 no compare in lock", err_cnt_o, 0);
    for (int i = 0; i < 63; i++) begin send(s9[p]); p++; end
    chk(pass_o == 0, "R6 pass at 63", pass_o, 0);
    send(s9[p]); p++;
    chk(pass_o == 1, "R6 pass at 64", pass_o, 1);
    chk(err_cnt_o == 0, "R5 clean count", err_cnt_o, 0);

    // R7/R8: single error then clean bits
    send(~s9[p]); p++;
    chk(pass_o == 0, "R7 fail on error", pass_o, 0);
    chk(err_cnt_o == 1, "R8 one error", err_cnt_o, 1);
    for (int i = 0; i < 100; i++) begin send(s9[p]); p++; end
    chk(pass_o == 0, "R7 latched", pass_o, 0);
    chk(err_cnt_o == 1, "R8 no extra", err_cnt_o, 1);

    // R8 saturation
    for (int i = 0; i < 300; i++) begin
      send(~s9[p]); p++;
      if (i == 253) chk(err_cnt_o == 255, "R8 reach max", err_cnt_o, 255);
      if (i == 252) chk(err_cnt_o == 254, "R8 below max", err_cnt_o, 254);
    end
    chk(err_cnt_o == 255, "R8 saturated", err_cnt_o, 255);

    // R9: restart clears, then pass and stop clears
    wr(1'b1);
    chk(err_cnt_o == 0, "R9 cnt clear", err_cnt_o, 0);
    chk(pass_o == 0, "R9 pass clear", pass_o, 0);
    p = 500;
    for (int i = 0; i < 9 + 64; i++) begin send(s9[p]); p++; end
    chk(pass_o == 1, "R6 pass again", pass_o, 1);
    wr(1'b0);
    chk(pass_o == 0, "R9 stop clears pass", pass_o, 0);
    chk(tx_vld_o == 0, "R4 stopped", tx_vld_o, 0);

    // R11: bits while stopped
    for (int i = 0; i < 40; i++) send(~s9[i]);
    chk(err_cnt_o == 0, "R11 stopped count", err_cnt_o, 0);
    chk(pass_o == 0, "R11 stopped pass", pass_o, 0);

    // R3/R10: long sequence, select flipped mid-run
    seq_sel_i = 1'b1;
    wr(1'b1);
    seq_sel_i = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      chk(tx_bit_o == s15[i], "R3 R10 tx bit", tx_bit_o, s15[i]);
      @(posedge clk_i); #1;
    end

    seq_sel_i = 1'b1;
    wr(1'b1);
    seq_sel_i = 1'b0;
    p = 200;
    for (int i = 0; i < 15; i++) begin send(s15[p]); p++; end
    chk(err_cnt_o == 0, "R5 long lock", err_cnt_o, 0);
    for (int i = 0; i < 63; i++) begin send(s15[p]); p++; end
    chk(pass_o == 0, "R6 long at 63", pass_o, 0);
    send(s15[p]); p++;
    chk(pass_o == 1, "R10 R6 long at 64", pass_o, 1);
    send(~s15[p]); p++;
    chk(err_cnt_o == 1, "R8 long error", err_cnt_o, 1);
    chk(pass_o == 0, "R7 long fail", pass_o, 0);

    wr(1'b0);
    chk(tx_vld_o == 0, "R4 final stop", tx_vld_o, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule